// File: doc/BRIEF.md
# Byte/Word Memory Bus Decoder

This block sits between a 16-bit processor memory bus and the memory and peripheral regions behind it. For each access it takes a 16-bit byte address, a size flag (byte or word), an access strobe, a write flag and 16-bit write data. It selects exactly one target region, or none. It places write data and byte enables on the right lanes in little-endian order, and it returns read data with a byte read zero-extended.

Each region has its own width rule. The system-register window and the narrow peripheral window take only bytes. The wide peripheral window takes only words. Every memory region takes both. A word access must use an even address. A word at an odd address, a width the region refuses, or an address that maps to no region raises a flag. Any of these also blocks the write strobe. The misalignment and width errors also produce a registered one-cycle error pulse. The decode itself is combinational. Three address bounds are parameters: the top of RAM, the top of information memory and the bottom of main flash.

Top module: `mbd_bus_decoder`

## Requirements
- R1: `region_sel` is one-hot from the address alone. The windows are: bit0 0x0000–0x000F (system registers), bit1 0x0010–0x00FF (byte peripherals), bit2 0x0100–0x01FF (word peripherals), bit3 0x0200–RAM_END (default 0x027F, RAM), bit4 0x1000–INFO_END (default 0x10FF, information memory), bit5 0x0C00–0x0FFF (boot memory), bit6 FLASH_START–0xFFDF (default 0xF800, main flash), bit7 0xFFE0–0xFFFF (vector table).
- R2: An address in no window gives `region_sel` = 0. During an access it raises `err_unmapped` and keeps `mem_wr` low.
- R3: A word access (`cpu_word`=1) with address bit 0 set raises `err_align` and keeps `mem_wr` low.
- R4: A word access to bit0 or bit1 regions, or a byte access to the bit2 region, raises `err_width` and keeps `mem_wr` low. Both widths are legal in regions bit3–bit7.
- R5: A byte access drives `mem_be` = 2'b01 at an even address and 2'b10 at an odd address. `mem_wdata` carries the write byte on both lanes.
- R6: A word access drives `mem_be` = 2'b11, and `mem_wdata` equals `cpu_wdata` (low byte in bits 7:0, at the even address).
- R7: `cpu_rdata` equals `mem_rdata` for a word. For a byte it is {8'h00, the lane chosen by address bit 0}.
- R8: `mem_wr` is high exactly when the strobe and the write flag are high, the address is mapped, and there is neither an alignment error nor a width error.
- R9: `err_pulse` is high for the one cycle after a clock edge at which an access had an alignment or width error, and is low otherwise. It is low after a synchronous active-low reset.
- R10: With `cpu_en` low, `mem_be`, `mem_wr` and all three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_en | input | 1 | Access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = word, 0 = byte |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 16 | Write data (a byte uses bits 7:0) |
| cpu_rdata | output | 16 | Read data returned to the processor |
| mem_rdata | input | 16 | Read data from the selected region |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_be | output | 2 | Byte-lane enables {high, low} |
| mem_wr | output | 1 | Write strobe to the selected region |
| region_sel | output | 8 | One-hot region select |
| err_align | output | 1 | Misaligned word access |
| err_width | output | 1 | Width not allowed by region |
| err_unmapped | output | 1 | Address maps to no region |
| err_pulse | output | 1 | Registered one-cycle error pulse |

## Verification
The bench drives directed accesses at every window edge: the first and last byte of each region and the bytes just outside RAM, information memory and flash. These show whether each bound comparison is off by one. Random accesses then pick a region or a gap, an offset, a size, an odd or even address and a write flag. This mix tells lane steering apart from size handling, and width refusals apart from alignment faults. Idle cycles with a faulty address present show that the flags follow the strobe. A reset applied during a faulty access shows that the pulse is cleared.

// File: rtl/mbd_pkg.sv
// Package: shared widths and region indices for the bus decoder.
// Assumes a 16-bit byte address and a 16-bit two-lane data bus.
package mbd_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;
    localparam int NREG   = 8;

    typedef enum int {
        RG_SYS   = 0,
        RG_PER8  = 1,
        RG_PER16 = 2,
        RG_RAM   = 3,
        RG_INFO  = 4,
        RG_BOOT  = 5,
        RG_FLASH = 6,
        RG_VEC   = 7
    } region_e;
endpackage

// File: rtl/mbd_region_dec.sv
// Region decoder: maps a byte address onto a one-hot region select and
// reports the width rule of the hit region. Purely combinational.
// Assumes the windows do not overlap for the parameter values chosen.
module mbd_region_dec
    import mbd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_END     = 16'h027F,
    parameter logic [ADDR_W-1:0] INFO_END    = 16'h10FF,
    parameter logic [ADDR_W-1:0] FLASH_START = 16'hF800
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel,
    output logic              mapped,
    output logic              byte_only,
    output logic              word_only
);
    logic [ADDR_W-1:0] lo_b [NREG];
    logic [ADDR_W-1:0] hi_b [NREG];

    // Window bounds per region
    always_comb begin
        lo_b[RG_SYS]   = 16'h0000; hi_b[RG_SYS]   = 16'h000F;
        lo_b[RG_PER8]  = 16'h0010; hi_b[RG_PER8]  = 16'h00FF;
        lo_b[RG_PER16] = 16'h0100; hi_b[RG_PER16] = 16'h01FF;
        lo_b[RG_RAM]   = 16'h0200; hi_b[RG_RAM]   = RAM_END;
        lo_b[RG_INFO]  = 16'h1000; hi_b[RG_INFO]  = INFO_END;
        lo_b[RG_BOOT]  = 16'h0C00; hi_b[RG_BOOT]  = 16'h0FFF;
        lo_b[RG_FLASH] = FLASH_START; hi_b[RG_FLASH] = 16'hFFDF;
        lo_b[RG_VEC]   = 16'hFFE0; hi_b[RG_VEC]   = 16'hFFFF;
    end

    // One range comparator per region
    for (genvar g = 0; g < NREG; g++) begin : g_win
        assign sel[g] = (addr >= lo_b[g]) && (addr <= hi_b[g]);
    end

    // Width rules of the hit region
    always_comb begin
        mapped    = |sel;
        byte_only = sel[RG_SYS] | sel[RG_PER8];
        word_only = sel[RG_PER16];
    end
endmodule

// File: rtl/mbd_lane_steer.sv
// Lane steering: builds byte enables and write data in little-endian
// order, and zero-extends byte reads. Purely combinational.
// Assumes two 8-bit lanes; address bit 0 picks the lane for a byte.
module mbd_lane_steer
    import mbd_pkg::*;
(
    input  logic              en,
    input  logic              word,
    input  logic              a0,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] rdata_out
);
    // Byte enables: both lanes for a word, one lane for a byte
    always_comb begin
        if (!en)       be = '0;
        else if (word) be = '1;
        else           be = a0 ? 2'b10 : 2'b01;
    end

    // Write data: a byte is copied onto both lanes
    always_comb begin
        wdata_out = word ? wdata_in : {wdata_in[7:0], wdata_in[7:0]};
    end

    // Read data: the selected byte lands zero-extended in the low byte
    always_comb begin
        if (word)    rdata_out = rdata_in;
        else if (a0) rdata_out = {8'h00, rdata_in[15:8]};
        else         rdata_out = {8'h00, rdata_in[7:0]};
    end
endmodule

// File: rtl/mbd_err_pulse.sv
// Error pulse register: emits a one-cycle pulse after any access that
// had an alignment or width fault. Synchronous active-low reset.
module mbd_err_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    output logic pulse
);
    // Capture this cycle's fault for exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= fault;
    end

    // R9
    pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> pulse);
    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |=> !pulse);
endmodule

// File: rtl/mbd_bus_decoder.sv
// Top of the byte/word bus decoder. It selects a region from the address,
// steers lanes, flags misaligned, width-refused and unmapped accesses,
// and blocks the write strobe on any of these.
// Assumes the address and data inputs hold steady while cpu_en is high.
module mbd_bus_decoder
    import mbd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_END     = 16'h027F,
    parameter logic [ADDR_W-1:0] INFO_END    = 16'h10FF,
    parameter logic [ADDR_W-1:0] FLASH_START = 16'hF800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_en,
    input  logic              cpu_wr,
    input  logic              cpu_word,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_be,
    output logic              mem_wr,
    output logic [NREG-1:0]   region_sel,
    output logic              err_align,
    output logic              err_width,
    output logic              err_unmapped,
    output logic              err_pulse
);
    logic mapped, byte_only, word_only;

    mbd_region_dec #(
        .RAM_END(RAM_END), .INFO_END(INFO_END), .FLASH_START(FLASH_START)
    ) dec_i (
        .addr(cpu_addr), .sel(region_sel), .mapped(mapped),
        .byte_only(byte_only), .word_only(word_only)
    );

    mbd_lane_steer steer_i (
        .en(cpu_en), .word(cpu_word), .a0(cpu_addr[0]),
        .wdata_in(cpu_wdata), .rdata_in(mem_rdata),
        .be(mem_be), .wdata_out(mem_wdata), .rdata_out(cpu_rdata)
    );

    // Fault classification for the current access
    always_comb begin
        err_align    = cpu_en & cpu_word & cpu_addr[0];
        err_width    = cpu_en & ((byte_only & cpu_word) | (word_only & ~cpu_word));
        err_unmapped = cpu_en & ~mapped;
    end

    // Write strobe only for a clean, mapped access
    always_comb begin
        mem_wr = cpu_en & cpu_wr & mapped & ~err_align & ~err_width;
    end

    mbd_err_pulse pulse_i (
        .clk(clk), .rst_n(rst_n), .fault(err_align | err_width), .pulse(err_pulse)
    );

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_sel));
    // R3
    misalign_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && cpu_word && cpu_addr[0]) |-> !mem_wr);
    // R4
    width_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_width |-> !mem_wr);
    // R2
    unmapped_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region_sel == '0) |-> !mem_wr);
    // R5
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && !cpu_word) |-> ($countones(mem_be) == 1));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_en |-> (mem_be == '0 && !mem_wr && !err_align && !err_width && !err_unmapped));
endmodule

// File: tb/mbd_bus_decoder_tb.sv
`timescale 1ns/100ps
module mbd_bus_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_en = 1'b0, cpu_wr = 1'b0, cpu_word = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0, mem_rdata = '0;
    logic [15:0] cpu_rdata, mem_wdata;
    logic [1:0]  mem_be;
    logic        mem_wr, err_align, err_width, err_unmapped, err_pulse;
    logic [7:0]  region_sel;

    int n_tests = 0, n_fail = 0;
    bit exp_pulse_next = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mbd_bus_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_wr(cpu_wr),
        .cpu_word(cpu_word), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_wr(mem_wr), .region_sel(region_sel),
        .err_align(err_align), .err_width(err_width),
        .err_unmapped(err_unmapped), .err_pulse(err_pulse)
    );

    // Reference region index from R1; -1 means unmapped (R2)
    function automatic int ref_region(input logic [15:0] a);
        if (a <= 16'h000F) return 0;
        if (a <= 16'h00FF) return 1;
        if (a <= 16'h01FF) return 2;
        if (a <= 16'h027F) return 3;
        if (a >= 16'h0C00 && a <= 16'h0FFF) return 5;
        if (a >= 16'h1000 && a <= 16'h10FF) return 4;
        if (a >= 16'hF800 && a <= 16'hFFDF) return 6;
        if (a >= 16'hFFE0) return 7;
        return -1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h word=%0b en=%0b: actual=%h expected=%h",
                     req, cpu_addr, cpu_word, cpu_en, act, exp);
        end
    endtask

    // Apply one cycle of stimulus and check every output against the reference
    task automatic access(input bit en, input bit wr, input bit word,
                          input logic [15:0] a, input logic [15:0] wd,
                          input logic [15:0] rd);
        int  r;
        bit  mapped, bo, wo, al, wi, un;
        logic [1:0]  be;
        logic [15:0] ewd, erd;
        @(negedge clk);
        cpu_en = en; cpu_wr = wr; cpu_word = word;
        cpu_addr = a; cpu_wdata = wd; mem_rdata = rd;
        #1;
        r      = ref_region(a);
        mapped = (r >= 0);
        bo     = (r == 0 || r == 1);
        wo     = (r == 2);
        al     = en && word && a[0];
        wi     = en && ((bo && word) || (wo && !word));
        un     = en && !mapped;
        be     = !en ? 2'b00 : word ? 2'b11 : (a[0] ? 2'b10 : 2'b01);
        ewd    = word ? wd : {wd[7:0], wd[7:0]};
        erd    = word ? rd : (a[0] ? {8'h00, rd[15:8]} : {8'h00, rd[7:0]});
        chk("R1 region_sel", region_sel, mapped ? (8'h01 << r) : 8'h00);
        chk("R2 err_unmapped", err_unmapped, un);
        chk("R3 err_align", err_align, al);
        chk("R4 err_width", err_width, wi);
        chk("R5/R6/R10 mem_be", mem_be, be);
        chk("R5/R6 mem_wdata", mem_wdata, ewd);
        chk("R7 cpu_rdata", cpu_rdata, erd);
        chk("R8 mem_wr", mem_wr, en && wr && mapped && !al && !wi);
        chk("R9 err_pulse", err_pulse, exp_pulse_next);
        exp_pulse_next = rst_n && (al || wi);
    endtask

    initial begin
        logic [15:0] edges [24];
        int seed;
        seed = $urandom(32'h5EED_0447);
        edges = '{16'h0000, 16'h000F, 16'h0010, 16'h00FF, 16'h0100, 16'h01FF,
                  16'h0200, 16'h027F, 16'h0280, 16'h0BFF, 16'h0C00, 16'h0FFF,
                  16'h1000, 16'h10FF, 16'h1100, 16'hF7FF, 16'hF800, 16'hFFDF,
                  16'hFFE0, 16'hFFFF, 16'h0101, 16'h0201, 16'hF801, 16'h0003};
        // Reset state (R9)
        repeat (3) @(posedge clk);
        #1 chk("R9 err_pulse after reset", err_pulse, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // R1 R2 boundary sweep, byte and word, read and write
        foreach (edges[i]) begin
            access(1, 1, 0, edges[i], 16'hA55A, 16'h1234);
            access(1, 1, 1, edges[i], 16'hBEEF, 16'hCAFE);
            access(1, 0, 0, edges[i] | 16'h1, 16'h0000, 16'h9876);
        end
        // R10 idle with faulty address, following a faulty access (R9 clears)
        access(1, 1, 1, 16'h0003, 16'h1111, 16'h2222);
        access(0, 1, 1, 16'h0003, 16'h1111, 16'h2222);
        access(0, 1, 0, 16'h0500, 16'h1111, 16'h2222);
        // R3 word at odd address in RAM, R4 byte in word window
        access(1, 1, 1, 16'h0211, 16'h7777, 16'h0000);
        access(1, 1, 0, 16'h0120, 16'h7777, 16'h0000);

        // R9 reset during a faulty access clears the pulse
        @(negedge clk);
        cpu_en = 1; cpu_wr = 1; cpu_word = 1; cpu_addr = 16'h0005; rst_n = 1'b0;
        @(posedge clk); #1 chk("R9 err_pulse cleared by reset", err_pulse, 1'b0);
        @(negedge clk) rst_n = 1'b1; cpu_en = 0;
        exp_pulse_next = 0;

        // Constrained random mix
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] a;
            int pick;
            pick = $urandom_range(0, 9);
            case (pick)
                0: a = 16'($urandom_range(16'h0000, 16'h000F));
                1: a = 16'($urandom_range(16'h0010, 16'h00FF));
                2: a = 16'($urandom_range(16'h0100, 16'h01FF));
                3: a = 16'($urandom_range(16'h0200, 16'h027F));
                4: a = 16'($urandom_range(16'h1000, 16'h10FF));
                5: a = 16'($urandom_range(16'h0C00, 16'h0FFF));
                6: a = 16'($urandom_range(16'hF800, 16'hFFDF));
                7: a = 16'($urandom_range(16'hFFE0, 16'hFFFF));
                default: a = 16'($urandom);
            endcase
            access(($urandom_range(0, 7) != 0), 1'($urandom), 1'($urandom),
                   a, 16'($urandom), 16'($urandom));
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule